// File: doc/BRIEF.md
# Power Mode Sequencer

This block sequences the operating modes of a supply-and-driver companion chip. The modes are Reset, Normal Request, Normal Run, Stop and Sleep. Each mode drives a fixed set of outputs: the active-low reset to the host, the regulator enable and its low-current select, the gate for the high-side switches, the bus transceiver mode, the sense amplifier enable and the watchdog mode. Mode changes come from a supply power-good input, from host mode commands delivered by a register interface, from watchdog events, and from wake sources. The wake sources are a bus wake, two local input levels and a chip-select line.

After power is good the block holds Reset for a fixed number of cycles and then enters Normal Request. In Normal Request a Run command from the host moves it to Normal Run. While the watchdog is enabled, a fixed timeout applies in Normal Request. That timeout is derived from the clock frequency and a 150 ms period. In Run, a window violation reported by the external watchdog returns the block to Reset. From Run the host may select Stop, which keeps the regulator on at low current, or Sleep, which turns the regulator off. A wake from Stop returns straight to Normal Request without a reset. A wake from Sleep passes through Reset.

Top module: `pwr_mode_seq`

## Requirements
- R1: `rst` or a low `pgood` puts the block in Reset. It leaves Reset for Normal Request after exactly `HOLD_CYC` (default 16) consecutive clock edges in Reset with `pgood` high.
- R2: A low `pgood` at a clock edge moves the block to Reset from any mode and restarts the hold count.
- R3: The outputs as {rst_n_out, vreg_en, vreg_lowi, sw_en, bus_mode, sense_en} are fixed per mode: Reset 0,1,0,0,0,0; Normal Request 1,1,0,1,1,0; Run 1,1,0,1,1,1; Stop 1,1,1,0,2,0; Sleep 0,0,0,0,2,0. The `bus_mode` encoding is 0 = held recessive, 1 = transmit/receive, 2 = recessive with wake detection.
- R4: In Normal Request, `cmd_valid` with `cmd_code` = 1 (Run) moves the block to Run at that edge. This command takes priority over a timeout in the same cycle.
- R5: In Normal Request with `wd_en` high, the block returns to Reset after `TMO_CYC` = CLK_HZ*150/1000 edges without a Run command. A `wd_kick` pulse restarts this count. With `wd_en` low no timeout occurs.
- R6: In Run, `wd_viol` sends the block to Reset when `wd_en` is high. When `wd_en` is low it is ignored.
- R7: `cmd_code` = 2 (Stop) and `cmd_code` = 3 (Sleep) are accepted only in Run. In Normal Request they have no effect.
- R8: In Stop, a high `wake_bus`, a change on either bit of `loc_in`, or a rising edge of `cs_in` moves the block to Normal Request at the next edge, with `rst_n_out` kept high.
- R9: In Sleep, a high `wake_bus` or a change on `loc_in` moves the block to Reset, after which the R1 hold applies. A rising edge on `cs_in` does not wake Sleep.
- R10: `wd_mode` is 1 (fixed timeout) in Normal Request and 2 (window) in Run while `wd_en` is high. It is 0 (off) in every other case.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pgood | input | 1 | Supply power-good |
| cmd_valid | input | 1 | Host mode command strobe |
| cmd_code | input | 2 | Command: 1 Run, 2 Stop, 3 Sleep |
| wd_en | input | 1 | Watchdog enable |
| wd_kick | input | 1 | Watchdog service strobe |
| wd_viol | input | 1 | Window violation from the watchdog |
| wake_bus | input | 1 | Bus wake detected |
| loc_in | input | N_LOC | Local wake input levels |
| cs_in | input | 1 | Chip-select level |
| rst_n_out | output | 1 | Active-low reset to the host |
| vreg_en | output | 1 | Regulator enable |
| vreg_lowi | output | 1 | Regulator low-current select |
| sw_en | output | 1 | High-side switch enable gate |
| bus_mode | output | 2 | Transceiver mode |
| sense_en | output | 1 | Sense amplifier enable |
| wd_mode | output | 2 | Watchdog mode |

## Verification
The assertions check the one-cycle rules on every cycle, using only the outputs. These rules are: a low power-good forces Reset, the switch gate implies a released reset and a full-current regulator, the watchdog is off whenever the switches are off, a Run command in Normal Request and a bus wake in Stop take effect at the next edge, a window violation in Run resets, and a quiet Sleep stays asleep. The exact 16-cycle hold, the 150 ms timeout length and its restart by a service pulse can only be shown by the bench's scenarios. So can the full sequences through Stop and Sleep, and the rule that a chip-select edge ignored in Sleep does wake Stop.

// File: rtl/pms_pkg.sv
package pms_pkg;

    typedef enum logic [2:0] {
        MD_RESET = 3'd0,
        MD_NREQ  = 3'd1,
        MD_RUN   = 3'd2,
        MD_STOP  = 3'd3,
        MD_SLEEP = 3'd4
    } mode_e;

    typedef enum logic [1:0] {
        BUS_HOLD = 2'd0,
        BUS_TXRX = 2'd1,
        BUS_WAKE = 2'd2
    } bus_e;

    typedef enum logic [1:0] {
        WD_OFF = 2'd0,
        WD_TMO = 2'd1,
        WD_WIN = 2'd2
    } wdm_e;

    localparam logic [1:0] CMD_RUN   = 2'd1;
    localparam logic [1:0] CMD_STOP  = 2'd2;
    localparam logic [1:0] CMD_SLEEP = 2'd3;

    typedef struct packed {
        logic rst_n;
        logic vreg_en;
        logic vreg_lowi;
        logic sw_en;
        bus_e bus;
        logic sense_en;
        wdm_e wd;
    } drive_t;

    // Fixed output group of each mode; watchdog mode qualified by enable.
    function automatic drive_t mode_drive(mode_e m, logic wd_en);
        drive_t d;
        d = '{rst_n: 1'b0, vreg_en: 1'b1, vreg_lowi: 1'b0, sw_en: 1'b0,
              bus: BUS_HOLD, sense_en: 1'b0, wd: WD_OFF};
        case (m)
            MD_NREQ: begin
                d.rst_n = 1'b1;
                d.sw_en = 1'b1;
                d.bus   = BUS_TXRX;
                d.wd    = wd_en ? WD_TMO : WD_OFF;
            end
            MD_RUN: begin
                d.rst_n    = 1'b1;
                d.sw_en    = 1'b1;
                d.bus      = BUS_TXRX;
                d.sense_en = 1'b1;
                d.wd       = wd_en ? WD_WIN : WD_OFF;
            end
            MD_STOP: begin
                d.rst_n     = 1'b1;
                d.vreg_lowi = 1'b1;
                d.bus       = BUS_WAKE;
            end
            MD_SLEEP: begin
                d.vreg_en = 1'b0;
                d.bus     = BUS_WAKE;
            end
            default: ;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/pms_timer.sv
module pms_timer #(
    parameter int LIMIT = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic expired
);
    localparam int W = $clog2(LIMIT + 1);

    logic [W-1:0] cnt;

    assign expired = run && (cnt == W'(LIMIT - 1));

    always_ff @(posedge clk) begin
        if (rst || !run || expired) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/pms_wake_det.sv
module pms_wake_det #(
    parameter int N_LOC = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N_LOC-1:0] loc_in,
    input  logic             cs_in,
    output logic             loc_chg,
    output logic             cs_rise
);
    logic [N_LOC-1:0] loc_q;
    logic [N_LOC-1:0] bit_chg;
    logic             cs_q;

    for (genvar i = 0; i < N_LOC; i++) begin : g_loc
        assign bit_chg[i] = loc_in[i] ^ loc_q[i];
    end

    assign loc_chg = |bit_chg;
    assign cs_rise = cs_in & ~cs_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            loc_q <= '0;
            cs_q  <= 1'b0;
        end else begin
            loc_q <= loc_in;
            cs_q  <= cs_in;
        end
    end
endmodule

// File: rtl/pms_mode_fsm.sv
module pms_mode_fsm
    import pms_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       pgood,
    input  logic       cmd_valid,
    input  logic [1:0] cmd_code,
    input  logic       wd_en,
    input  logic       wd_viol,
    input  logic       hold_done,
    input  logic       nreq_tmo,
    input  logic       wake_bus,
    input  logic       loc_chg,
    input  logic       cs_rise,
    output mode_e      mode
);
    mode_e nxt;
    logic  is_run, is_stop, is_sleep;

    assign is_run   = cmd_valid && (cmd_code == CMD_RUN);
    assign is_stop  = cmd_valid && (cmd_code == CMD_STOP);
    assign is_sleep = cmd_valid && (cmd_code == CMD_SLEEP);

    always_comb begin
        nxt = mode;
        if (!pgood) begin
            nxt = MD_RESET;
        end else begin
            case (mode)
                MD_RESET: if (hold_done) nxt = MD_NREQ;
                MD_NREQ: begin
                    if (is_run)        nxt = MD_RUN;
                    else if (nreq_tmo) nxt = MD_RESET;
                end
                MD_RUN: begin
                    if (wd_en && wd_viol) nxt = MD_RESET;
                    else if (is_stop)     nxt = MD_STOP;
                    else if (is_sleep)    nxt = MD_SLEEP;
                end
                MD_STOP:  if (wake_bus || loc_chg || cs_rise) nxt = MD_NREQ;
                MD_SLEEP: if (wake_bus || loc_chg) nxt = MD_RESET;
                default:  nxt = MD_RESET;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) mode <= MD_RESET;
        else     mode <= nxt;
    end
endmodule

// File: rtl/pwr_mode_seq.sv
module pwr_mode_seq
    import pms_pkg::*;
#(
    parameter int CLK_HZ   = 20_000_000,
    parameter int TMO_MS   = 150,
    parameter int HOLD_CYC = 16,
    parameter int N_LOC    = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pgood,
    input  logic             cmd_valid,
    input  logic [1:0]       cmd_code,
    input  logic             wd_en,
    input  logic             wd_kick,
    input  logic             wd_viol,
    input  logic             wake_bus,
    input  logic [N_LOC-1:0] loc_in,
    input  logic             cs_in,
    output logic             rst_n_out,
    output logic             vreg_en,
    output logic             vreg_lowi,
    output logic             sw_en,
    output logic [1:0]       bus_mode,
    output logic             sense_en,
    output logic [1:0]       wd_mode
);
    localparam longint TMO_L   = (longint'(CLK_HZ) * longint'(TMO_MS)) / 64'd1000;
    localparam int     TMO_CYC = (TMO_L < 2) ? 2 : int'(TMO_L);

    mode_e  mode;
    drive_t drv;
    logic   hold_run, hold_done;
    logic   tmo_run, nreq_tmo;
    logic   loc_chg, cs_rise;

    assign hold_run = (mode == MD_RESET) && pgood;
    assign tmo_run  = (mode == MD_NREQ) && pgood && wd_en && !wd_kick;

    pms_timer #(.LIMIT(HOLD_CYC)) u_hold (
        .clk(clk), .rst(rst), .run(hold_run), .expired(hold_done)
    );

    pms_timer #(.LIMIT(TMO_CYC)) u_tmo (
        .clk(clk), .rst(rst), .run(tmo_run), .expired(nreq_tmo)
    );

    pms_wake_det #(.N_LOC(N_LOC)) u_wake (
        .clk(clk), .rst(rst), .loc_in(loc_in), .cs_in(cs_in),
        .loc_chg(loc_chg), .cs_rise(cs_rise)
    );

    pms_mode_fsm u_fsm (
        .clk(clk), .rst(rst), .pgood(pgood),
        .cmd_valid(cmd_valid), .cmd_code(cmd_code),
        .wd_en(wd_en), .wd_viol(wd_viol),
        .hold_done(hold_done), .nreq_tmo(nreq_tmo),
        .wake_bus(wake_bus), .loc_chg(loc_chg), .cs_rise(cs_rise),
        .mode(mode)
    );

    assign drv       = mode_drive(mode, wd_en);
    assign rst_n_out = drv.rst_n;
    assign vreg_en   = drv.vreg_en;
    assign vreg_lowi = drv.vreg_lowi;
    assign sw_en     = drv.sw_en;
    assign bus_mode  = drv.bus;
    assign sense_en  = drv.sense_en;
    assign wd_mode   = drv.wd;
endmodule

// File: rtl/pms_checker.sv
module pms_checker #(
    parameter int N_LOC = 2
) (
    input logic             clk,
    input logic             rst,
    input logic             pgood,
    input logic             cmd_valid,
    input logic [1:0]       cmd_code,
    input logic             wd_en,
    input logic             wd_viol,
    input logic             wake_bus,
    input logic [N_LOC-1:0] loc_in,
    input logic             rst_n_out,
    input logic             vreg_en,
    input logic             vreg_lowi,
    input logic             sw_en,
    input logic [1:0]       bus_mode,
    input logic             sense_en,
    input logic [1:0]       wd_mode
);
    a_r2_pgood_low_resets: assert property (@(posedge clk) disable iff (rst)
        !pgood |=> (!rst_n_out && vreg_en && !sw_en && bus_mode == 2'd0));

    a_r3_switch_needs_release: assert property (@(posedge clk) disable iff (rst)
        sw_en |-> (rst_n_out && vreg_en && !vreg_lowi));

    a_r3_sense_needs_switch: assert property (@(posedge clk) disable iff (rst)
        sense_en |-> sw_en);

    a_r10_wd_off_without_switch: assert property (@(posedge clk) disable iff (rst)
        !sw_en |-> (wd_mode == 2'd0));

    a_r4_run_cmd_taken: assert property (@(posedge clk) disable iff (rst)
        (pgood && sw_en && !sense_en && cmd_valid && cmd_code == 2'd1) |=> sense_en);

    a_r6_window_violation: assert property (@(posedge clk) disable iff (rst)
        (pgood && sense_en && wd_en && wd_viol) |=> !rst_n_out);

    a_r7_no_low_power_from_request: assert property (@(posedge clk) disable iff (rst)
        (pgood && sw_en && !sense_en) |=> (vreg_en && !vreg_lowi));

    a_r8_stop_bus_wake: assert property (@(posedge clk) disable iff (rst)
        (pgood && vreg_lowi && wake_bus) |=> (rst_n_out && sw_en && !sense_en));

    a_r9_quiet_sleep_holds: assert property (@(posedge clk) disable iff (rst)
        (pgood && !vreg_en && !wake_bus && $stable(loc_in)) |=> !vreg_en);
endmodule

bind pwr_mode_seq pms_checker #(.N_LOC(N_LOC)) u_pms_checker (
    .clk(clk), .rst(rst), .pgood(pgood), .cmd_valid(cmd_valid),
    .cmd_code(cmd_code), .wd_en(wd_en), .wd_viol(wd_viol),
    .wake_bus(wake_bus), .loc_in(loc_in), .rst_n_out(rst_n_out),
    .vreg_en(vreg_en), .vreg_lowi(vreg_lowi), .sw_en(sw_en),
    .bus_mode(bus_mode), .sense_en(sense_en), .wd_mode(wd_mode)
);

// File: tb/pwr_mode_seq_bench.sv
module pwr_mode_seq_bench;
    localparam int CLK_HZ = 200;   // gives a 30-cycle Normal Request timeout
    localparam int TMO    = 30;

    // Expected {rst_n, vreg_en, lowi, sw_en, bus[1:0], sense, wd[1:0]}
    localparam logic [8:0] X_RST  = 9'b0_1_0_0_00_0_00;
    localparam logic [8:0] X_NRQ  = 9'b1_1_0_1_01_0_01;
    localparam logic [8:0] X_NRQ0 = 9'b1_1_0_1_01_0_00;
    localparam logic [8:0] X_RUN  = 9'b1_1_0_1_01_1_10;
    localparam logic [8:0] X_RUN0 = 9'b1_1_0_1_01_1_00;
    localparam logic [8:0] X_STP  = 9'b1_1_1_0_10_0_00;
    localparam logic [8:0] X_SLP  = 9'b0_0_0_0_10_0_00;

    // Stimulus {pgood, cmd_valid, cmd[1:0], wd_en, kick, viol, wake, loc[1:0], cs}
    localparam int NV = 11;
    localparam logic [19:0] VEC [NV] = '{
        {11'b1_0_00_1_0_0_0_00_0, X_NRQ},  // idle in request
        {11'b1_1_10_1_0_0_0_00_0, X_NRQ},  // R7 stop ignored in request
        {11'b1_1_01_1_0_0_0_00_0, X_RUN},  // R4 run command
        {11'b1_0_00_1_0_0_0_00_0, X_RUN},
        {11'b1_1_10_1_0_0_0_00_0, X_STP},  // R7 stop from run
        {11'b1_0_00_1_0_0_0_00_1, X_NRQ},  // R8 cs rise wakes stop
        {11'b1_1_01_1_0_0_0_00_1, X_RUN},
        {11'b1_1_11_1_0_0_0_00_1, X_SLP},  // R7 sleep from run
        {11'b1_0_00_1_0_0_0_00_0, X_SLP},
        {11'b1_0_00_1_0_0_0_00_1, X_SLP},  // R9 cs rise ignored in sleep
        {11'b1_0_00_1_0_0_0_01_1, X_RST}   // R9 local change wakes via reset
    };

    logic       clk = 1'b0;
    logic       rst, pgood, cmd_valid, wd_en, wd_kick, wd_viol, wake_bus, cs_in;
    logic [1:0] cmd_code, loc_in;
    logic       rst_n_out, vreg_en, vreg_lowi, sw_en, sense_en;
    logic [1:0] bus_mode, wd_mode;
    int         n_cmp = 0;
    int         n_bad = 0;

    pwr_mode_seq #(.CLK_HZ(CLK_HZ)) u_pwr_mode_seq (
        .clk(clk), .rst(rst), .pgood(pgood), .cmd_valid(cmd_valid),
        .cmd_code(cmd_code), .wd_en(wd_en), .wd_kick(wd_kick),
        .wd_viol(wd_viol), .wake_bus(wake_bus), .loc_in(loc_in),
        .cs_in(cs_in), .rst_n_out(rst_n_out), .vreg_en(vreg_en),
        .vreg_lowi(vreg_lowi), .sw_en(sw_en), .bus_mode(bus_mode),
        .sense_en(sense_en), .wd_mode(wd_mode)
    );

    always #5 clk = ~clk;

    wire [8:0] obs = {rst_n_out, vreg_en, vreg_lowi, sw_en, bus_mode, sense_en, wd_mode};

    task automatic tick(input int n);
        repeat (n) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic chk(input string req, input logic [8:0] exp);
        n_cmp++;
        if (obs !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %b expected %b", req, obs, exp);
        end
    endtask

    task automatic send(input logic [1:0] code);
        cmd_valid = 1'b1;
        cmd_code  = code;
        tick(1);
        cmd_valid = 1'b0;
        cmd_code  = 2'd0;
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        #500000;
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual hung expected finished");
        finish_run();
    end

    initial begin
        rst = 1'b1; pgood = 1'b1; cmd_valid = 1'b0; cmd_code = 2'd0;
        wd_en = 1'b1; wd_kick = 1'b0; wd_viol = 1'b0; wake_bus = 1'b0;
        loc_in = 2'b00; cs_in = 1'b0;
        tick(3);
        chk("R1 reset state", X_RST);
        rst = 1'b0;
        tick(15);
        chk("R1 hold 15 edges", X_RST);
        tick(1);
        chk("R1 hold 16 edges", X_NRQ);

        for (int i = 0; i < NV; i++) begin
            {pgood, cmd_valid, cmd_code, wd_en, wd_kick, wd_viol,
             wake_bus, loc_in, cs_in} = VEC[i][19:9];
            tick(1);
            chk($sformatf("R3 vector %0d", i), VEC[i][8:0]);
        end
        cmd_valid = 1'b0; cmd_code = 2'd0; cs_in = 1'b0;

        tick(15);
        chk("R9 sleep wake holds reset", X_RST);
        tick(1);
        chk("R9 sleep wake reaches request", X_NRQ);

        // R5 exact timeout length
        tick(TMO - 1);
        chk("R5 before timeout", X_NRQ);
        tick(1);
        chk("R5 timeout", X_RST);
        tick(16);

        // R5 service pulse restarts the count
        tick(20);
        wd_kick = 1'b1;
        tick(1);
        wd_kick = 1'b0;
        tick(TMO - 1);
        chk("R5 kick restarts count", X_NRQ);
        tick(1);
        chk("R5 timeout after kick", X_RST);
        tick(16);

        // R5 / R10 watchdog disabled
        wd_en = 1'b0;
        tick(1);
        chk("R10 wd off in request", X_NRQ0);
        tick(TMO + 10);
        chk("R5 no timeout when disabled", X_NRQ0);
        send(2'd1);
        chk("R10 wd off in run", X_RUN0);
        wd_viol = 1'b1;
        tick(1);
        wd_viol = 1'b0;
        chk("R6 violation ignored when disabled", X_RUN0);
        wd_en = 1'b1;
        #1;
        chk("R10 window mode in run", X_RUN);
        wd_viol = 1'b1;
        tick(1);
        wd_viol = 1'b0;
        chk("R6 violation resets", X_RST);
        tick(16);

        // R8 stop wakes
        send(2'd1);
        send(2'd2);
        tick(5);
        chk("R8 quiet stop holds", X_STP);
        wake_bus = 1'b1;
        tick(1);
        wake_bus = 1'b0;
        chk("R8 bus wake from stop", X_NRQ);
        send(2'd1);
        send(2'd2);
        loc_in = 2'b11;
        tick(1);
        chk("R8 local change wakes stop", X_NRQ);

        // R9 bus wake from sleep
        send(2'd1);
        send(2'd3);
        tick(3);
        chk("R9 quiet sleep holds", X_SLP);
        wake_bus = 1'b1;
        tick(1);
        wake_bus = 1'b0;
        chk("R9 bus wake from sleep", X_RST);
        tick(16);

        // R2 power-good loss
        send(2'd1);
        pgood = 1'b0;
        tick(1);
        chk("R2 pgood low resets", X_RST);
        tick(5);
        pgood = 1'b1;
        tick(15);
        chk("R2 hold restarts", X_RST);
        tick(1);
        chk("R2 request after hold", X_NRQ);

        finish_run();
    end
endmodule